// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from a parameterizable number of sources and presents one interrupt line and vector to a single processor. Every source has its own programmable priority. The lowest-numbered sources can also be raised by software: any bus master that can reach the register port may write a set bit to post a request, and a clear bit both reports and withdraws it. This lets one processor hand work to another, or split an interrupt handler into an urgent part and a deferred part.

Nesting is tracked with a current-priority register and a last-in first-out stack of saved priorities. The stack has one entry for each priority level. Reading the acknowledge register returns the winning source, saves the old current priority on the stack and raises the current priority to the winner's level. Any write to the end-of-interrupt register restores the saved level. A request interrupts the core only when its priority is strictly above the current priority. Software is expected never to lower the current priority below that of the handler that is running. Doing so allows more nesting than the stack holds, and the controller records the overflow as an error.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the current priority is 0, every source priority is 0, no software request is pending, the error flag is 0 and `irq_o` is 0.
- R2: `irq_o` is 1 one cycle after a state in which some pending source has priority strictly above the current priority, and `irq_vec_o` then gives that source. Pending sources whose priority is equal to or below the current priority leave `irq_o` at 0.
- R3: The highest pending priority wins. Among equal priorities the lowest source index wins. A source whose priority is 0 never interrupts.
- R4: Software request k is the word at address 0x10+k and drives source k. Writing data bit 1 as 1 sets the request. Writing data bit 0 as 1 clears it. When both bits are 1, the set takes effect. Read data bit 0 is 1 while the request is pending.
- R5: A read of address 0x001 (acknowledge) returns the winning source index in read data bits [7:0]. It pushes the current priority onto the stack and loads the winner's priority into the current priority. It does not clear a software request.
- R6: An acknowledge with no source above the current priority returns the value NUM_SRC (232) and changes no state.
- R7: Any write to address 0x002 (end of interrupt) pops the stack into the current priority.
- R8: An end of interrupt on an empty stack sets the sticky error flag, which is read data bit 0 at address 0x003, and leaves the current priority unchanged. Writing 1 to bit 0 of that address clears the flag.
- R9: The stack holds 16 entries. An acknowledge on a full stack still returns the winner, but it sets the error flag and leaves the current priority and the stack unchanged.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd`. Address 0x000 holds the current priority in bits [3:0]; a write there loads it. Address 0x100+i holds the 4-bit priority of source i.
- R11: Each bit of `hw_irq_i` is a level request for the source with the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | NUM_SRC | Level requests from hardware sources |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | VEC_W | Index of the source that raises `irq_o` |

## Verification
The bench probes ties at equal priority and priority-0 sources. An arbiter that got these wrong would pick the higher index or raise a request for a disabled source. It holds a request at exactly the current priority, which catches a greater-or-equal comparison. It checks that acknowledge leaves a software request pending, so a design that cleared the request on acknowledge would lose the deferred work. It writes the set and clear bits together to check that the set takes effect. It drives an end of interrupt on an empty stack and seventeen nested acknowledges in a row. A design without bounds checks there would corrupt the current priority or miss the sticky error.

// File: rtl/pic_pkg.sv
// Package: shared register offsets and the register-select type for the
// nested priority interrupt controller. Assumes word addressing.
package pic_pkg;
    localparam int unsigned OFS_CUR   = 0;
    localparam int unsigned OFS_ACK   = 1;
    localparam int unsigned OFS_EOI   = 2;
    localparam int unsigned OFS_STAT  = 3;
    localparam int unsigned OFS_SWREQ = 16;
    localparam int unsigned OFS_PRIO  = 256;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CUR,
        SEL_ACK,
        SEL_EOI,
        SEL_STAT,
        SEL_SWREQ,
        SEL_PRIO
    } reg_sel_e;
endpackage

// File: rtl/pic_arbiter.sv
// Module: pic_arbiter
// Finds the pending source with the highest priority; a tie goes to the lowest
// index. Priority 0 never wins. With no winner, the index is NUM_SRC.
// Assumes priorities arrive flattened, source i at bits [i*PRIO_W +: PRIO_W].
module pic_arbiter #(
    parameter int NUM_SRC = 232,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [VEC_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio,
    output logic                      win_any
);
    // Linear scan: replace the candidate only on a strictly higher priority.
    always_comb begin
        win_idx  = VEC_W'(NUM_SRC);
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
                win_idx  = VEC_W'(i);
            end
        end
        win_any = (win_prio != '0);
    end
endmodule

// File: rtl/pic_swreq.sv
// Module: pic_swreq
// Bank of software-posted requests, one flop per request. A set strobe wins
// over a clear strobe in the same cycle. Assumes the strobes are already decoded.
module pic_swreq #(
    parameter int NUM_SW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] set_strb,
    input  logic [NUM_SW-1:0] clr_strb,
    output logic [NUM_SW-1:0] pend
);
    for (genvar k = 0; k < NUM_SW; k++) begin : g_req
        // Hold one request: set has precedence, clear withdraws it.
        always_ff @(posedge clk) begin
            if (!rst_n)            pend[k] <= 1'b0;
            else if (set_strb[k])  pend[k] <= 1'b1;
            else if (clr_strb[k])  pend[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/pic_lifo.sv
// Module: pic_lifo
// Stack of saved priority levels. A push on a full stack or a pop on an empty
// one is ignored; the caller detects that through full/empty.
module pic_lifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign full   = (count == CNT_W'(DEPTH));
    assign empty  = (count == '0);
    assign wr_idx = IDX_W'(count);
    assign rd_idx = IDX_W'(count - CNT_W'(1));
    assign top    = empty ? '0 : mem[rd_idx];

    // Track the fill level; push and pop are never asked in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (push && !full)    count <= count + CNT_W'(1);
        else if (pop && !empty)    count <= count - CNT_W'(1);
    end

    // Store each saved level in the next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
        end else if (push && !full) begin
            mem[wr_idx] <= push_data;
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
// Module: pic_ctrl (top)
// Nested priority interrupt controller with a register port. It decodes
// register accesses, holds the source priorities and the current priority,
// and drives the registered interrupt output. Assumes reg_wr and reg_rd are
// not asserted together; if they are, the write is done and the read dropped.
module pic_ctrl #(
    parameter int NUM_SRC = 232,
    parameter int NUM_SW  = 8,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 32,
    localparam int VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_irq_i,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o,
    output logic [VEC_W-1:0]   irq_vec_o
);
    import pic_pkg::*;

    localparam int NUM_LVL = 1 << PRIO_W;
    localparam int CNT_W   = $clog2(NUM_LVL + 1);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CUR);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
    localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(OFS_EOI);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(OFS_SWREQ);
    localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(OFS_PRIO);
    localparam logic [ADDR_W-1:0] N_SW   = ADDR_W'(NUM_SW);
    localparam logic [ADDR_W-1:0] N_SRC  = ADDR_W'(NUM_SRC);

    reg_sel_e                  sel;
    logic [ADDR_W-1:0]         sw_idx;
    logic [ADDR_W-1:0]         prio_idx;
    logic                      do_wr;
    logic                      do_rd;
    logic [PRIO_W-1:0]         cur_prio_q;
    logic                      err_q;
    logic [PRIO_W-1:0]         prio_q [NUM_SRC];
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SW-1:0]         sw_set;
    logic [NUM_SW-1:0]         sw_clr;
    logic [NUM_SW-1:0]         sw_pend;
    logic [NUM_SRC-1:0]        pend;
    logic [VEC_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic                      win_any;
    logic                      win_valid;
    logic                      ack;
    logic                      eoi;
    logic                      push;
    logic                      pop;
    logic [PRIO_W-1:0]         lifo_top;
    logic [CNT_W-1:0]          lifo_cnt;
    logic                      lifo_full;
    logic                      lifo_empty;
    logic [PRIO_W-1:0]         prio_rd;
    logic                      sw_rd;
    logic                      unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:PRIO_W];
    assign do_wr    = reg_wr;
    assign do_rd    = reg_rd && !reg_wr;
    assign sw_idx   = reg_addr - A_SW;
    assign prio_idx = reg_addr - A_PRIO;

    // Map the word address onto a register group.
    always_comb begin
        sel = SEL_NONE;
        if (reg_addr == A_CUR)                               sel = SEL_CUR;
        else if (reg_addr == A_ACK)                          sel = SEL_ACK;
        else if (reg_addr == A_EOI)                          sel = SEL_EOI;
        else if (reg_addr == A_STAT)                         sel = SEL_STAT;
        else if (reg_addr >= A_SW && sw_idx < N_SW)          sel = SEL_SWREQ;
        else if (reg_addr >= A_PRIO && prio_idx < N_SRC)     sel = SEL_PRIO;
    end

    // Per-source priority registers and their flattened view for the arbiter.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[i] <= '0;
            else if (do_wr && sel == SEL_PRIO && prio_idx == ADDR_W'(i))
                prio_q[i] <= reg_wdata[PRIO_W-1:0];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // Set and clear strobes for the software request bank.
    for (genvar k = 0; k < NUM_SW; k++) begin : g_swstrb
        assign sw_set[k] = do_wr && sel == SEL_SWREQ && sw_idx == ADDR_W'(k) && reg_wdata[1];
        assign sw_clr[k] = do_wr && sel == SEL_SWREQ && sw_idx == ADDR_W'(k) && reg_wdata[0];
    end

    pic_swreq #(.NUM_SW(NUM_SW)) u_swreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_strb (sw_set),
        .clr_strb (sw_clr),
        .pend     (sw_pend)
    );

    assign pend = hw_irq_i | {{(NUM_SRC-NUM_SW){1'b0}}, sw_pend};

    pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
        .pend      (pend),
        .prio_flat (prio_flat),
        .win_idx   (win_idx),
        .win_prio  (win_prio),
        .win_any   (win_any)
    );

    assign win_valid = win_any && (win_prio > cur_prio_q);
    assign ack       = do_rd && sel == SEL_ACK;
    assign eoi       = do_wr && sel == SEL_EOI;
    assign push      = ack && win_valid && !lifo_full;
    assign pop       = eoi && !lifo_empty;

    pic_lifo #(.DEPTH(NUM_LVL), .WIDTH(PRIO_W), .CNT_W(CNT_W)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (cur_prio_q),
        .top       (lifo_top),
        .count     (lifo_cnt),
        .full      (lifo_full),
        .empty     (lifo_empty)
    );

    // Current priority: software load, raise on acknowledge, restore on end of interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cur_prio_q <= '0;
        else if (do_wr && sel == SEL_CUR)       cur_prio_q <= reg_wdata[PRIO_W-1:0];
        else if (push)                          cur_prio_q <= win_prio;
        else if (pop)                           cur_prio_q <= lifo_top;
    end

    // Sticky error on stack overflow or underflow; write 1 to bit 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        err_q <= 1'b0;
        else if ((ack && win_valid && lifo_full) || (eoi && lifo_empty))
                                                           err_q <= 1'b1;
        else if (do_wr && sel == SEL_STAT && reg_wdata[0]) err_q <= 1'b0;
    end

    // Select the priority and software request addressed for a read.
    always_comb begin
        prio_rd = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (prio_idx == ADDR_W'(i)) prio_rd = prio_q[i];
        sw_rd = 1'b0;
        for (int k = 0; k < NUM_SW; k++)
            if (sw_idx == ADDR_W'(k)) sw_rd = sw_pend[k];
    end

    // Registered read data, one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (do_rd) begin
            case (sel)
                SEL_CUR:   reg_rdata <= DATA_W'(cur_prio_q);
                SEL_ACK:   reg_rdata <= DATA_W'(win_valid ? win_idx : VEC_W'(NUM_SRC));
                SEL_STAT:  reg_rdata <= DATA_W'(err_q);
                SEL_SWREQ: reg_rdata <= DATA_W'(sw_rd);
                SEL_PRIO:  reg_rdata <= DATA_W'(prio_rd);
                default:   reg_rdata <= '0;
            endcase
        end
    end

    // Registered request and vector to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            irq_vec_o <= VEC_W'(NUM_SRC);
        end else begin
            irq_o     <= win_valid;
            irq_vec_o <= win_idx;
        end
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
// Module: pic_ctrl_chk
// Assertion checker for pic_ctrl, bound to every instance. It watches the
// register port, the outputs, the current priority, the stack fill level and
// the error flag.
module pic_ctrl_chk #(
    parameter int NUM_SRC = 232,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 9,
    parameter int CNT_W   = 5,
    parameter int VEC_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              stat_clr_bit,
    input logic              irq_o,
    input logic [VEC_W-1:0]  irq_vec_o,
    input logic [PRIO_W-1:0] cur_prio,
    input logic [CNT_W-1:0]  lifo_cnt,
    input logic              err
);
    localparam int DEPTH = 1 << PRIO_W;

    // R1: reset clears the interrupt output and the current priority
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && cur_prio == '0 && lifo_cnt == '0 && !err));

    // R2: a raised request always carries a real source index
    p_vec_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_vec_o < VEC_W'(NUM_SRC)));

    // R5: an acknowledge never lowers the current priority
    p_ack_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == ADDR_W'(1)) |=> (cur_prio >= $past(cur_prio)));

    // R7: end of interrupt on a non-empty stack removes exactly one entry
    p_eoi_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(2) && lifo_cnt != '0)
        |=> (lifo_cnt == $past(lifo_cnt) - CNT_W'(1)));

    // R8: end of interrupt on an empty stack flags an error and keeps the priority
    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(2) && lifo_cnt == '0)
        |=> (err && $stable(cur_prio)));

    // R8: the error flag holds until cleared through the status register
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr && reg_addr == ADDR_W'(3) && stat_clr_bit)) |=> err);

    // R9: the stack never holds more entries than there are levels
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lifo_cnt <= CNT_W'(DEPTH));
endmodule

bind pic_ctrl pic_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .VEC_W   (VEC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .stat_clr_bit (reg_wdata[0]),
    .irq_o        (irq_o),
    .irq_vec_o    (irq_vec_o),
    .cur_prio     (cur_prio_q),
    .lifo_cnt     (lifo_cnt),
    .err          (err_q)
);

// File: tb/sim_pic_ctrl.sv
// Scoreboard bench for pic_ctrl. Driver tasks queue the expected read data;
// a monitor compares each read result when it appears.
module sim_pic_ctrl;
    localparam int NUM_SRC = 232;
    localparam int ADDR_W  = 9;
    localparam int DATA_W  = 32;
    localparam int VEC_W   = 8;
    localparam logic [ADDR_W-1:0] A_CUR = 9'h000, A_ACK = 9'h001, A_EOI = 9'h002,
                                  A_STAT = 9'h003, A_SW = 9'h010, A_PRIO = 9'h100;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] hw_irq_i = '0;
    logic               reg_wr = 1'b0;
    logic               reg_rd = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic               irq_o;
    logic [VEC_W-1:0]   irq_vec_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    rd_d = 1'b0;
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    always #4 clk = ~clk;

    pic_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .hw_irq_i (hw_irq_i),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq_o (irq_o), .irq_vec_o (irq_vec_o)
    );

    // Note which cycles carried a read so the monitor knows when data is due.
    always @(posedge clk) rd_d <= reg_rd && rst_n;

    // Monitor: pop the expected item and compare it with the read data.
    always @(negedge clk) begin
        if (rd_d) begin
            logic [DATA_W-1:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: read data %0d with nothing expected", "scoreboard", reg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read data %0d expected %0d", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hw(input int idx, input logic v);
        @(negedge clk);
        hw_irq_i[idx] = v;
    endtask

    task automatic chk_irq(input logic ei, input int ev, input string t);
        @(negedge clk);
        checks++;
        if (irq_o !== ei || (ei && irq_vec_o !== VEC_W'(ev))) begin
            errors++;
            $display("FAIL %s: irq %0b vec %0d expected irq %0b vec %0d", t, irq_o, irq_vec_o, ei, ev);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        chk_irq(1'b0, 0, "R1");
        rd(A_CUR, 0, "R1 cur");
        rd(A_STAT, 0, "R1 stat");
        rd(A_SW, 0, "R1 swreq");
        rd(A_PRIO + 5, 0, "R1 prio");
        // R3: pending at priority 0 never interrupts; R4 set reads back
        wr(A_SW, 32'h2);
        chk_irq(1'b0, 0, "R3 prio0");
        rd(A_SW, 1, "R4 set");
        // R10 priority write/readback; R2 request raised
        wr(A_PRIO + 0, 3);
        rd(A_PRIO + 0, 3, "R10 prio");
        chk_irq(1'b1, 0, "R2 raise");
        // R11/R3 tie at equal priority goes to the lower index
        wr(A_PRIO + 100, 3);
        hw(100, 1'b1);
        chk_irq(1'b1, 0, "R3 tie");
        wr(A_PRIO + 50, 7);
        hw(50, 1'b1);
        chk_irq(1'b1, 50, "R3 higher R11");
        // R5 acknowledge
        rd(A_ACK, 50, "R5 ack vec");
        rd(A_CUR, 7, "R5 cur raised");
        chk_irq(1'b0, 0, "R2 lower waits");
        wr(A_PRIO + 60, 7);
        hw(60, 1'b1);
        chk_irq(1'b0, 0, "R2 equal waits");
        wr(A_PRIO + 70, 9);
        hw(70, 1'b1);
        chk_irq(1'b1, 70, "R2 preempt");
        rd(A_ACK, 70, "R5 nested ack");
        rd(A_CUR, 9, "R5 cur nested");
        // R7 end of interrupt restores levels in reverse order
        wr(A_EOI, 0);
        rd(A_CUR, 7, "R7 pop1");
        wr(A_EOI, 0);
        rd(A_CUR, 0, "R7 pop2");
        hw(50, 1'b0); hw(60, 1'b0); hw(70, 1'b0);
        // R5 acknowledge leaves the software request pending
        rd(A_ACK, 0, "R5 sw ack");
        rd(A_SW, 1, "R5 sw kept");
        rd(A_CUR, 3, "R5 cur sw");
        wr(A_EOI, 0);
        // R4 clear, and set wins over clear
        wr(A_SW, 32'h1);
        rd(A_SW, 0, "R4 clr");
        wr(A_SW + 1, 32'h3);
        rd(A_SW + 1, 1, "R4 set wins");
        wr(A_SW + 1, 32'h1);
        rd(A_SW + 1, 0, "R4 clr1");
        hw(100, 1'b0);
        // R6 spurious acknowledge
        rd(A_ACK, NUM_SRC, "R6 spurious");
        rd(A_CUR, 0, "R6 cur kept");
        rd(A_STAT, 0, "R6 no err");
        // R8 underflow
        wr(A_EOI, 0);
        rd(A_STAT, 1, "R8 err set");
        rd(A_CUR, 0, "R8 cur kept");
        wr(A_STAT, 1);
        rd(A_STAT, 0, "R8 err clr");
        // R10 current priority load
        wr(A_CUR, 5);
        rd(A_CUR, 5, "R10 cur wr");
        // R9 overflow after 16 nested entries
        wr(A_PRIO + 200, 1);
        hw(200, 1'b1);
        for (int n = 0; n < 16; n++) begin
            wr(A_CUR, 0);
            rd(A_ACK, 200, "R9 fill");
        end
        rd(A_STAT, 0, "R9 not yet");
        wr(A_CUR, 0);
        rd(A_ACK, 200, "R9 full ack");
        rd(A_CUR, 0, "R9 cur kept");
        rd(A_STAT, 1, "R9 err set");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule